// File: doc/BRIEF.md
# Maskable Bus Protocol Rule Checker

This block sits beside a 64-bit PCI-X style bus and only watches it. The bus control lines are active low. On every clock it evaluates nine timing and handshake rules in parallel. These cover initiator framing, initiator readiness, target claim timing, target termination timing, 64-bit handshaking, target ready continuity and a bus-hang watchdog. A decoded address-phase marker comes from outside the block. The attribute phase is taken to be the clock that follows it.

Each rule has its own mask bit. A rule that fires while unmasked updates four records: a sticky per-rule list, a saturating violation count, a captured first-violation rule number and a one-bit violation output. Software-side logic loads the masks and the hang limit through write strobes, and a clear strobe wipes the records.

Top module: `bus_rule_checker`

## Requirements
- R1: A mask bit of 1 blocks its rule: that rule changes neither the violation output, the list, the count nor the first-violation capture. A mask bit of 0 lets the rule through. Mask bit i belongs to rule i, and all masks are 0 after reset.
- R2: The first clock with any unmasked firing latches first_valid and a rule number that holds until clear. When several rules fire in that clock, the lowest number is kept.
- R3: `fired` bit i is set when rule i fires unmasked, and it stays set until clear.
- R4: All records are registered. `viol` is high in the clock after a clock in which at least one unmasked rule fired, and low otherwise.
- R5: `viol_cnt` adds the number of unmasked rules that fired in each clock, and it saturates at its all-ones value.
- R6: Rule 0 covers a bus hang. The bus is busy when the frame line or the initiator-ready line is low. Rule 0 fires on the busy clock that follows `limit` consecutive busy clocks. The limit can be 1 to 4095, and a limit of 0 (the reset value) disables the rule.
- R7: Rule 1 fires when the frame line rises while initiator-ready is high. Rule 2 fires when the frame line falls while, in the previous clock, frame was high and initiator-ready was low, which is the same transaction.
- R8: Rule 3 fires if initiator-ready is low one or two clocks after the address phase, or high three clocks after it. Rule 4 fires when initiator-ready rises while, in the previous clock, frame was low and target-stop was high.
- R9: Rule 5 fires when target-claim falls 1 clock, 5 clocks, or more than 6 clocks after the address phase. Clocks are counted from the marker until the bus goes idle.
- R10: Rule 6 fires when a termination code begins more than 8 clocks after the address phase. The codes, with 0 meaning asserted, are: retry (claim 0, stop 0, ready 1), abort (claim 1, stop 0, ready 1) and split response (claim 1, stop 1, ready 0).
- R11: Rule 7 fires when the 64-bit acknowledge falls without a 64-bit request at the address phase of the current transaction. Rule 8 fires when target-ready falls after it has already been asserted and released in the same transaction.
- R12: `clr` empties the list, the count and the first-violation capture, and it re-arms the capture. Clear wins over a firing in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| adr_mark | input | 1 | High in the address-phase clock |
| ini_hold_n | input | 1 | Initiator frame line, low while framed |
| ini_ready_n | input | 1 | Initiator ready, active low |
| tgt_ready_n | input | 1 | Target ready, active low |
| tgt_claim_n | input | 1 | Target select/claim, active low |
| tgt_halt_n | input | 1 | Target stop, active low |
| wide_req_n | input | 1 | 64-bit transfer request, active low |
| wide_ack_n | input | 1 | 64-bit transfer acknowledge, active low |
| mask_wr | input | 1 | Load strobe for mask_din |
| mask_din | input | 9 | Per-rule mask value |
| limit_wr | input | 1 | Load strobe for limit_din |
| limit_din | input | LIMW | Hang limit in clocks |
| clr | input | 1 | Clears list, count and first capture |
| viol | output | 1 | Registered unmasked-violation flag |
| first_valid | output | 1 | A first violation is held |
| first_rule | output | 4 | Number of the first unmasked rule |
| fired | output | 9 | Sticky per-rule list |
| viol_cnt | output | CNTW | Saturating violation count |

## Verification
The rules are first tried against legal traffic: a 64-bit burst with a claim two clocks after the address phase, a wait state and a clean end. This shows that none of them fires falsely. Transactions that each break particular rules follow, including one clock in which two rules break together, which separates the lowest-number capture from a plain latch. Boundary patterns set a termination at exactly 8 clocks against one at 9, and a hang at limit+1 busy clocks against a disabled limit. Long runs of acknowledge toggles check count saturation, and a masked and then unmasked firing separates the mask from the rule.

// File: rtl/bus_rule_checker.sv
module bus_rule_checker #(
  parameter int LIMW = 12,
  parameter int CNTW = 8,
  parameter int PHW  = 5,
  parameter logic [LIMW-1:0] LIMIT_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adr_mark,
  input  logic            ini_hold_n,
  input  logic            ini_ready_n,
  input  logic            tgt_ready_n,
  input  logic            tgt_claim_n,
  input  logic            tgt_halt_n,
  input  logic            wide_req_n,
  input  logic            wide_ack_n,
  input  logic            mask_wr,
  input  logic [8:0]      mask_din,
  input  logic            limit_wr,
  input  logic [LIMW-1:0] limit_din,
  input  logic            clr,
  output logic            viol,
  output logic            first_valid,
  output logic [3:0]      first_rule,
  output logic [8:0]      fired,
  output logic [CNTW-1:0] viol_cnt
);
  localparam int NR = 9;
  localparam int RW = 4;

  logic [NR-1:0]   mask_q, raw, hits, sticky_q;
  logic [LIMW-1:0] limit_q;
  logic [LIMW:0]   busy_q;
  logic [PHW-1:0]  ph_q;
  logic [2:0]      am_q;
  logic p_hold, p_ready, p_tready, p_claim, p_stop, p_ack;
  logic term_p, req_seen, t_on, t_off;
  logic [CNTW-1:0] cnt_q;
  logic            first_v, viol_q;
  logic [RW-1:0]   first_q, low_idx;
  logic [CNTW:0]   sum;

  wire idle     = ini_hold_n & ini_ready_n;
  wire term_now = (!tgt_halt_n & tgt_ready_n) | (tgt_claim_n & tgt_halt_n & !tgt_ready_n);

  assign raw[0] = (limit_q != '0) && !idle && (busy_q == {1'b0, limit_q});
  assign raw[1] = ini_hold_n && !p_hold && ini_ready_n;
  assign raw[2] = !ini_hold_n && p_hold && !p_ready;
  assign raw[3] = ((am_q[0] | am_q[1]) && !ini_ready_n) || (am_q[2] && ini_ready_n);
  assign raw[4] = ini_ready_n && !p_ready && !p_hold && p_stop;
  assign raw[5] = !tgt_claim_n && p_claim &&
                  (ph_q == PHW'(1) || ph_q == PHW'(5) || ph_q > PHW'(6));
  assign raw[6] = term_now && !term_p && (ph_q > PHW'(8));
  assign raw[7] = !wide_ack_n && p_ack && !req_seen;
  assign raw[8] = !tgt_ready_n && p_tready && t_off;

  assign hits = raw & ~mask_q;
  assign sum  = {1'b0, cnt_q} + (CNTW+1)'($countones(hits));

  always_comb begin
    low_idx = '0;
    for (int i = NR-1; i >= 0; i--)
      if (hits[i]) low_idx = RW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      limit_q  <= LIMIT_RST;
      busy_q   <= '0;
      ph_q     <= '0;
      am_q     <= '0;
      p_hold   <= 1'b1;
      p_ready  <= 1'b1;
      p_tready <= 1'b1;
      p_claim  <= 1'b1;
      p_stop   <= 1'b1;
      p_ack    <= 1'b1;
      term_p   <= 1'b0;
      req_seen <= 1'b0;
      t_on     <= 1'b0;
      t_off    <= 1'b0;
    end else begin
      if (mask_wr)  mask_q  <= mask_din;
      if (limit_wr) limit_q <= limit_din;
      if (idle)                busy_q <= '0;
      else if (!busy_q[LIMW])  busy_q <= busy_q + 1'b1;
      if (adr_mark)                         ph_q <= PHW'(1);
      else if (idle)                        ph_q <= '0;
      else if (ph_q != '0 && ph_q != '1)    ph_q <= ph_q + 1'b1;
      am_q     <= {am_q[1:0], adr_mark};
      p_hold   <= ini_hold_n;
      p_ready  <= ini_ready_n;
      p_tready <= tgt_ready_n;
      p_claim  <= tgt_claim_n;
      p_stop   <= tgt_halt_n;
      p_ack    <= wide_ack_n;
      term_p   <= term_now;
      if (adr_mark)  req_seen <= !wide_req_n;
      else if (idle) req_seen <= 1'b0;
      if (adr_mark) begin
        t_on  <= 1'b0;
        t_off <= 1'b0;
      end else begin
        if (!tgt_ready_n)        t_on  <= 1'b1;
        if (t_on && tgt_ready_n) t_off <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q   <= 1'b0;
      sticky_q <= '0;
      cnt_q    <= '0;
      first_v  <= 1'b0;
      first_q  <= '0;
    end else begin
      viol_q <= |hits;
      if (clr) begin
        sticky_q <= '0;
        cnt_q    <= '0;
        first_v  <= 1'b0;
        first_q  <= '0;
      end else begin
        sticky_q <= sticky_q | hits;
        cnt_q    <= sum[CNTW] ? '1 : sum[CNTW-1:0];
        if (!first_v && |hits) begin
          first_v <= 1'b1;
          first_q <= low_idx;
        end
      end
    end
  end

  assign viol        = viol_q;
  assign first_valid = first_v;
  assign first_rule  = first_q;
  assign fired       = sticky_q;
  assign viol_cnt    = cnt_q;
endmodule

// File: rtl/bus_rule_checker_sva.sv
module bus_rule_checker_sva #(
  parameter int CNTW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr,
  input logic [8:0]      hits,
  input logic            viol,
  input logic [8:0]      sticky,
  input logic [CNTW-1:0] cnt,
  input logic            first_v,
  input logic [3:0]      first_rule
);
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && hits == '0) |=> ($stable(sticky) && $stable(cnt) && !viol)); // R1

  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (first_v && !clr) |=> (first_v && $stable(first_rule))); // R2

  AST_FIRE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && hits != '0) |=> (viol && ((sticky & $past(hits)) == $past(hits)))); // R3

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt))); // R5

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sticky == '0 && cnt == '0 && !first_v)); // R12
endmodule

bind bus_rule_checker bus_rule_checker_sva #(.CNTW(CNTW)) u_sva (
  .clk(clk), .rst_n(rst_n), .clr(clr), .hits(hits), .viol(viol_q),
  .sticky(sticky_q), .cnt(cnt_q), .first_v(first_v), .first_rule(first_q)
);

// File: tb/bus_rule_checker_tb_top.sv
module bus_rule_checker_tb_top;
  localparam int CNTW = 8;
  localparam int NT   = 52;
  // row: {adr, frame_n, irdy_n, trdy_n, claim_n, stop_n, req_n, ack_n, expected rule bits}
  localparam logic [16:0] TBL [NT] = '{
    {8'h7F, 9'h000}, {8'hBD, 9'h000}, {8'h3D, 9'h000}, {8'h34, 9'h000},  // legal burst
    {8'h14, 9'h000}, {8'h04, 9'h000}, {8'h46, 9'h000}, {8'h7F, 9'h000},
    {8'hBF, 9'h000}, {8'h36, 9'h0A0},                                    // R9 claim at 1, R11 ack w/o req
    {8'h36, 9'h000}, {8'h06, 9'h000}, {8'h16, 9'h000}, {8'h06, 9'h100},  // R11 ready re-assert
    {8'h46, 9'h000}, {8'h7F, 9'h000},
    {8'hBF, 9'h000}, {8'h3F, 9'h000}, {8'h3F, 9'h000}, {8'h3F, 9'h008},  // R8 ready late
    {8'h7F, 9'h002},                                                     // R7 frame up w/o ready
    {8'hBF, 9'h000}, {8'h3F, 9'h000}, {8'h3F, 9'h000}, {8'h1F, 9'h000},
    {8'h5F, 9'h000}, {8'h1F, 9'h004},                                    // R7 frame re-assert
    {8'h3F, 9'h010}, {8'h7F, 9'h002},                                    // R8 ready dropped
    {8'hBF, 9'h000}, {8'h3F, 9'h000}, {8'h3F, 9'h000}, {8'h1F, 9'h000},
    {8'h1F, 9'h000}, {8'h17, 9'h020},                                    // R9 claim at 5
    {8'h17, 9'h000}, {8'h17, 9'h000}, {8'h17, 9'h000}, {8'h13, 9'h040},  // R10 retry at 9
    {8'h53, 9'h000}, {8'h7F, 9'h000},
    {8'hBF, 9'h000}, {8'h3F, 9'h000}, {8'h3F, 9'h000}, {8'h1F, 9'h000},
    {8'h1F, 9'h000}, {8'h1F, 9'h000}, {8'h1F, 9'h000}, {8'h1F, 9'h000},
    {8'h1B, 9'h000},                                                     // R10 abort at 8 legal
    {8'h5B, 9'h000}, {8'h7F, 9'h000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic adr_mark = 1'b0, ini_hold_n = 1'b1, ini_ready_n = 1'b1, tgt_ready_n = 1'b1;
  logic tgt_claim_n = 1'b1, tgt_halt_n = 1'b1, wide_req_n = 1'b1, wide_ack_n = 1'b1;
  logic mask_wr = 1'b0, limit_wr = 1'b0, clr = 1'b0;
  logic [8:0] mask_din = '0;
  logic [11:0] limit_din = '0;
  logic viol, first_valid;
  logic [3:0] first_rule;
  logic [8:0] fired;
  logic [CNTW-1:0] viol_cnt;
  int nchk = 0, nfail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  bus_rule_checker #(.CNTW(CNTW)) dut_i (
    .clk(clk), .rst_n(rst_n), .adr_mark(adr_mark), .ini_hold_n(ini_hold_n),
    .ini_ready_n(ini_ready_n), .tgt_ready_n(tgt_ready_n), .tgt_claim_n(tgt_claim_n),
    .tgt_halt_n(tgt_halt_n), .wide_req_n(wide_req_n), .wide_ack_n(wide_ack_n),
    .mask_wr(mask_wr), .mask_din(mask_din), .limit_wr(limit_wr), .limit_din(limit_din),
    .clr(clr), .viol(viol), .first_valid(first_valid), .first_rule(first_rule),
    .fired(fired), .viol_cnt(viol_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] v);
    @(negedge clk);
    {adr_mark, ini_hold_n, ini_ready_n, tgt_ready_n, tgt_claim_n, tgt_halt_n, wide_req_n, wide_ack_n} = v;
    @(posedge clk);
    #5;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic set_mask(input logic [8:0] m);
    @(negedge clk); mask_wr = 1'b1; mask_din = m;
    @(negedge clk); mask_wr = 1'b0;
  endtask

  task automatic set_limit(input logic [11:0] l);
    @(negedge clk); limit_wr = 1'b1; limit_din = l;
    @(negedge clk); limit_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [8:0] exp_st;
    int exp_cnt;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #5;
    chk("R4 reset viol", viol, 0);
    chk("R3 reset list", fired, 0);
    chk("R5 reset count", viol_cnt, 0);
    chk("R2 reset first_valid", first_valid, 0);

    exp_st = '0; exp_cnt = 0;
    for (int k = 0; k < NT; k++) begin
      logic [8:0] e;
      step(TBL[k][16:9]);
      e = TBL[k][8:0];
      exp_st |= e;
      exp_cnt += $countones(e);
      chk("R4 viol per row", viol, int'(e != '0));
      chk("R3 sticky list", fired, exp_st);
      chk("R5 running count", viol_cnt, exp_cnt);
    end
    chk("R2 first_valid after table", first_valid, 1);
    chk("R2 lowest of rules 5 and 7", first_rule, 5);

    pulse_clr(); #5;
    chk("R12 list cleared", fired, 0);
    chk("R12 count cleared", viol_cnt, 0);
    chk("R12 first cleared", first_valid, 0);

    step(8'hBF); step(8'h36);
    chk("R2 re-armed capture", first_valid, 1);
    chk("R2 lowest rule kept", first_rule, 5);
    chk("R9 claim at one clock", fired, 9'h0A0);
    step(8'h7F);
    chk("R2 first held after later rule", first_rule, 5);
    chk("R7 frame release without ready", fired, 9'h0A2);
    step(8'h7F);

    pulse_clr(); set_mask(9'h080);
    step(8'h7E);
    chk("R1 masked viol", viol, 0);
    chk("R1 masked list", fired, 0);
    chk("R1 masked count", viol_cnt, 0);
    chk("R1 masked first", first_valid, 0);
    step(8'h7F);
    set_mask(9'h000);
    step(8'h7E);
    chk("R1 unmasked viol", viol, 1);
    chk("R11 ack without request", fired, 9'h080);
    step(8'h7F);

    pulse_clr(); set_mask(9'h002); set_limit(12'd4);
    for (int i = 1; i <= 6; i++) begin
      step(8'h3F);
      chk("R6 hang at limit+1", viol, int'(i == 5));
    end
    chk("R6 hang recorded", fired, 9'h001);
    step(8'h7F);
    set_limit(12'd0); pulse_clr();
    for (int i = 0; i < 10; i++) begin
      step(8'h3F);
      chk("R6 limit zero disables", viol, 0);
    end
    step(8'h7F);
    chk("R6 nothing recorded when disabled", fired, 0);

    set_mask(9'h000); pulse_clr();
    for (int i = 0; i < 300; i++) begin
      step(8'h7E);
      step(8'h7F);
    end
    chk("R5 count saturates", viol_cnt, (1 << CNTW) - 1);
    chk("R2 first of saturation run", first_rule, 7);

    done = 1'b1;
    finish_run();
  end
endmodule